// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block walks one frame of a framebuffer in memory and emits burst read requests for it. Four configuration inputs describe the frame: the byte address of the first pixel, the bytes to fetch per line, the byte stride from one line start to the next, and the number of lines minus one. The fetch length and the stride are independent, so a frame can sit inside a wider buffer, and the base may point at any byte offset inside that buffer.

A one-cycle frame-start pulse captures the configuration. The generator then splits every line into bursts of at most sixteen beats, with a shorter last burst for the remainder. Each request carries an address and a beat count, and it is presented on a valid/ready handshake. The memory bus returns one completion pulse per finished request. The generator keeps no more than a set number of requests in flight. Once the last burst of the last line has been accepted, it raises a done flag and stays idle until the next frame start. Returned data and pixel unpacking are handled outside this block.

Top module: `fb_scan_addr_gen`

## Requirements
- R1: After reset, req_valid and done are low, and no request is issued until the first frame_start pulse.
- R2: frame_start captures cfg_base, cfg_line_bytes, cfg_pitch and cfg_lines_m1. Changes to these inputs during a frame do not alter the requests of that frame.
- R3: Line i (counted from 0) starts at base + i*pitch. A line needs ceil(line_bytes/BEAT_BYTES) beats, where BEAT_BYTES is 8 by default.
- R4: A line is split into bursts of MAX_BURST (16) beats, with a shorter final burst for the remainder. req_len carries the burst's beat count minus one. Each burst address is the previous one plus its beats times BEAT_BYTES.
- R5: A frame issues exactly cfg_lines_m1+1 lines of requests.
- R6: While req_valid is high and req_ready is low, req_valid stays high and req_addr and req_len stay unchanged, unless frame_start arrives.
- R7: At most MAX_OUTST (default 4) accepted requests are awaiting completion at any time. Each cpl_pulse frees one slot. A pulse that arrives while nothing is outstanding is ignored.
- R8: done rises in the cycle after the final burst's handshake. No request follows until the next frame_start, and frame_start clears done.
- R9: A frame_start that arrives in the middle of a frame abandons the rest of that frame and restarts from the new base.
- R10: With a line length of zero, the frame issues no requests and still ends with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W (32) | Byte address of the first fetched byte |
| cfg_line_bytes | input | LEN_W (16) | Bytes fetched per line |
| cfg_pitch | input | LEN_W (16) | Byte stride between line starts |
| cfg_lines_m1 | input | LCNT_W (12) | Line count minus one |
| frame_start | input | 1 | One-cycle pulse that starts or restarts a frame |
| req_valid | output | 1 | Request is valid |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | ADDR_W (32) | Burst start byte address |
| req_len | output | BL_W (4) | Burst beats minus one |
| cpl_pulse | input | 1 | One outstanding request has completed |
| done | output | 1 | Frame fully issued; generator is idle |

## Verification
The walk is tried with four shapes of line:
- A line that fits in one burst, which shows that the pitch is applied per line.
- A 25-beat line, which produces one full and one partial burst and so shows the split and the address advance inside a line.
- A 20-byte line, which shows that a partial beat is rounded up.
- A zero-length line, which shows that an empty frame still ends.

The flow-control tests use two patterns. In the first, the ready input is held low and the configuration is changed while a request waits. This separates payload stability from configuration capture. In the second, completions are withheld, which shows that the issue count stops at the limit and that exactly one more request goes out per completion. A restart in the middle of a frame shows that the new base replaces the old walk.

// File: rtl/scan_pkg.sv
package scan_pkg;
   typedef enum logic [1:0] {
      SC_IDLE = 2'd0,
      SC_RUN  = 2'd1,
      SC_DONE = 2'd2
   } scan_state_e;
endpackage

// File: rtl/scan_credit_ctr.sv
module scan_credit_ctr #(
   parameter int MAX_OUTST = 4,
   localparam int CW = (MAX_OUTST > 0) ? $clog2(MAX_OUTST + 1) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue,
   input  logic          retire,
   output logic          can_issue,
   output logic [CW-1:0] outst
);
   generate
      if (MAX_OUTST > 0) begin : g_limited
         logic [CW-1:0] cnt_q;
         logic          inc, dec;
         assign inc = issue;
         assign dec = retire && (cnt_q != '0);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (inc && !dec) begin
               cnt_q <= cnt_q + 1'b1;
            end else if (dec && !inc) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         assign can_issue = (cnt_q < CW'(MAX_OUTST));
         assign outst     = cnt_q;
      end else begin : g_unlimited
         assign can_issue = 1'b1;
         assign outst     = '0;
      end
   endgenerate
endmodule

// File: rtl/scan_burst_splitter.sv
module scan_burst_splitter #(
   parameter int ADDR_W     = 32,
   parameter int BEATS_W    = 14,
   parameter int MAX_BURST  = 16,
   parameter int BEAT_BYTES = 8,
   localparam int BL_W      = $clog2(MAX_BURST),
   localparam int BEAT_SH   = $clog2(BEAT_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [ADDR_W-1:0]  load_addr,
   input  logic [BEATS_W-1:0] load_beats,
   input  logic               take,
   output logic [ADDR_W-1:0]  cur_addr,
   output logic [BL_W-1:0]    burst_m1,
   output logic               last_burst,
   output logic               empty
);
   logic [ADDR_W-1:0]  addr_q;
   logic [BEATS_W-1:0] left_q;
   logic [BEATS_W-1:0] burst;
   logic               cap;

   assign cap        = (left_q >= BEATS_W'(MAX_BURST));
   assign burst      = cap ? BEATS_W'(MAX_BURST) : left_q;
   assign empty      = (left_q == '0);
   assign last_burst = !empty && !(left_q > BEATS_W'(MAX_BURST));
   assign burst_m1   = BL_W'(burst - 1'b1);
   assign cur_addr   = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         left_q <= '0;
      end else if (load) begin
         addr_q <= load_addr;
         left_q <= load_beats;
      end else if (take) begin
         addr_q <= addr_q + (ADDR_W'(burst) << BEAT_SH);
         left_q <= left_q - burst;
      end
   end
endmodule

// File: rtl/scan_line_walker.sv
module scan_line_walker #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int LCNT_W     = 12,
   parameter int BEAT_BYTES = 8,
   localparam int BEAT_SH   = $clog2(BEAT_BYTES),
   localparam int BEATS_W   = LEN_W - BEAT_SH + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  cfg_base,
   input  logic [LEN_W-1:0]   cfg_line_bytes,
   input  logic [LEN_W-1:0]   cfg_pitch,
   input  logic [LCNT_W-1:0]  cfg_lines_m1,
   input  logic               advance,
   output logic [BEATS_W-1:0] start_beats,
   output logic [BEATS_W-1:0] line_beats,
   output logic [ADDR_W-1:0]  next_addr,
   output logic               is_last_line
);
   logic [ADDR_W-1:0]  line_addr_q;
   logic [LEN_W-1:0]   pitch_q;
   logic [LCNT_W-1:0]  lines_m1_q;
   logic [LCNT_W-1:0]  idx_q;
   logic [BEATS_W-1:0] beats_q;
   logic [LEN_W:0]     len_round;

   assign len_round    = {1'b0, cfg_line_bytes} + (LEN_W+1)'(BEAT_BYTES - 1);
   assign start_beats  = BEATS_W'(len_round >> BEAT_SH);
   assign line_beats   = beats_q;
   assign next_addr    = line_addr_q + ADDR_W'(pitch_q);
   assign is_last_line = (idx_q == lines_m1_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_addr_q <= '0;
         pitch_q     <= '0;
         lines_m1_q  <= '0;
         idx_q       <= '0;
         beats_q     <= '0;
      end else if (start) begin
         line_addr_q <= cfg_base;
         pitch_q     <= cfg_pitch;
         lines_m1_q  <= cfg_lines_m1;
         idx_q       <= '0;
         beats_q     <= start_beats;
      end else if (advance) begin
         line_addr_q <= next_addr;
         idx_q       <= idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/fb_scan_addr_gen.sv
module fb_scan_addr_gen #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int LCNT_W     = 12,
   parameter int BEAT_BYTES = 8,
   parameter int MAX_BURST  = 16,
   parameter int MAX_OUTST  = 4,
   localparam int BL_W      = $clog2(MAX_BURST),
   localparam int BEAT_SH   = $clog2(BEAT_BYTES),
   localparam int BEATS_W   = LEN_W - BEAT_SH + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [LEN_W-1:0]  cfg_line_bytes,
   input  logic [LEN_W-1:0]  cfg_pitch,
   input  logic [LCNT_W-1:0] cfg_lines_m1,
   input  logic              frame_start,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic [BL_W-1:0]   req_len,
   input  logic              cpl_pulse,
   output logic              done
);
   import scan_pkg::*;

   generate
      if (BEAT_BYTES != (1 << BEAT_SH)) begin : g_bad_beat
         $error("BEAT_BYTES must be a power of two");
      end
      if (MAX_BURST != (1 << BL_W) || MAX_BURST < 2) begin : g_bad_burst
         $error("MAX_BURST must be a power of two of at least 2");
      end
      if (LEN_W <= BEAT_SH) begin : g_bad_len
         $error("LEN_W must exceed log2(BEAT_BYTES)");
      end
   endgenerate

   localparam int CW = (MAX_OUTST > 0) ? $clog2(MAX_OUTST + 1) : 1;

   scan_state_e        st_q, st_d;
   logic               hs, line_end, split_load, walk_adv;
   logic               can_issue, last_burst, empty, is_last_line;
   logic [CW-1:0]      outst;
   logic [BEATS_W-1:0] start_beats, line_beats, load_beats;
   logic [ADDR_W-1:0]  next_addr, load_addr, cur_addr;
   logic [BL_W-1:0]    burst_m1;

   assign req_valid  = (st_q == SC_RUN) && !empty && can_issue;
   assign hs         = req_valid && req_ready;
   assign line_end   = (st_q == SC_RUN) && ((hs && last_burst) || empty);
   assign split_load = frame_start || (line_end && !is_last_line);
   assign walk_adv   = !frame_start && line_end && !is_last_line;
   assign load_addr  = frame_start ? cfg_base : next_addr;
   assign load_beats = frame_start ? start_beats : line_beats;
   assign req_addr   = cur_addr;
   assign req_len    = burst_m1;
   assign done       = (st_q == SC_DONE);

   always_comb begin
      st_d = st_q;
      if (frame_start) begin
         st_d = SC_RUN;
      end else if (line_end && is_last_line) begin
         st_d = SC_DONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= SC_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   scan_line_walker #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LCNT_W(LCNT_W), .BEAT_BYTES(BEAT_BYTES)
   ) u_walker (
      .clk(clk), .rst_n(rst_n), .start(frame_start),
      .cfg_base(cfg_base), .cfg_line_bytes(cfg_line_bytes),
      .cfg_pitch(cfg_pitch), .cfg_lines_m1(cfg_lines_m1),
      .advance(walk_adv), .start_beats(start_beats), .line_beats(line_beats),
      .next_addr(next_addr), .is_last_line(is_last_line)
   );

   scan_burst_splitter #(
      .ADDR_W(ADDR_W), .BEATS_W(BEATS_W), .MAX_BURST(MAX_BURST),
      .BEAT_BYTES(BEAT_BYTES)
   ) u_split (
      .clk(clk), .rst_n(rst_n), .load(split_load), .load_addr(load_addr),
      .load_beats(load_beats), .take(hs), .cur_addr(cur_addr),
      .burst_m1(burst_m1), .last_burst(last_burst), .empty(empty)
   );

   scan_credit_ctr #(.MAX_OUTST(MAX_OUTST)) u_credit (
      .clk(clk), .rst_n(rst_n), .issue(hs), .retire(cpl_pulse),
      .can_issue(can_issue), .outst(outst)
   );
endmodule

// File: rtl/fb_scan_addr_gen_chk.sv
module fb_scan_addr_gen_chk #(
   parameter int ADDR_W    = 32,
   parameter int BL_W      = 4,
   parameter int MAX_OUTST = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [BL_W-1:0]   req_len,
   input logic              cpl_pulse,
   input logic              done
);
   logic [15:0] inflight;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inflight <= '0;
      end else begin
         case ({req_valid && req_ready, cpl_pulse && (inflight != '0)})
            2'b10:   inflight <= inflight + 1'b1;
            2'b01:   inflight <= inflight - 1'b1;
            default: inflight <= inflight;
         endcase
      end
   end

   // R6
   hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && !frame_start) |=>
         (req_valid && $stable(req_addr) && $stable(req_len)));

   // R7
   outst_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (MAX_OUTST > 0 && req_valid) |-> (inflight < 16'(MAX_OUTST)));

   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_valid);

   // R8
   start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !done);
endmodule

bind fb_scan_addr_gen fb_scan_addr_gen_chk #(
   .ADDR_W(ADDR_W), .BL_W(BL_W), .MAX_OUTST(MAX_OUTST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .req_valid(req_valid),
   .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
   .cpl_pulse(cpl_pulse), .done(done)
);

// File: tb/fb_scan_addr_gen_tb.sv
module fb_scan_addr_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_base = '0;
   logic [15:0] cfg_line_bytes = '0;
   logic [15:0] cfg_pitch = '0;
   logic [11:0] cfg_lines_m1 = '0;
   logic        frame_start = 1'b0;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [31:0] req_addr;
   logic [3:0]  req_len;
   logic        cpl_pulse = 1'b0;
   logic        done;

   int n_tests = 0, n_fail = 0;
   int hs_count = 0, pending = 0;
   bit ready_en = 0, auto_cpl = 1, cpl_once = 0;
   logic [31:0] rec_addr [64];
   logic [3:0]  rec_len  [64];

   always #10 clk = ~clk;

   fb_scan_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base),
      .cfg_line_bytes(cfg_line_bytes), .cfg_pitch(cfg_pitch),
      .cfg_lines_m1(cfg_lines_m1), .frame_start(frame_start),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_len(req_len), .cpl_pulse(cpl_pulse), .done(done)
   );

   always @(negedge clk) begin
      #1;
      req_ready = ready_en;
      if (cpl_once) begin
         cpl_pulse = 1'b1; cpl_once = 0;
         if (pending > 0) pending--;
      end else if (auto_cpl && pending > 0) begin
         cpl_pulse = 1'b1; pending--;
      end else begin
         cpl_pulse = 1'b0;
      end
      if (req_valid && req_ready) begin
         if (hs_count < 64) begin
            rec_addr[hs_count] = req_addr;
            rec_len[hs_count]  = req_len;
         end
         hs_count++;
         pending++;
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic start_frame(logic [31:0] b, logic [15:0] l, logic [15:0] p,
                              logic [11:0] n);
      @(negedge clk);
      cfg_base = b; cfg_line_bytes = l; cfg_pitch = p; cfg_lines_m1 = n;
      frame_start = 1'b1; hs_count = 0;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 2000 && !done; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      #3;
      check("R1 valid", {31'd0, req_valid}, 0);
      check("R1 done", {31'd0, done}, 0);
      ready_en = 1;
      repeat (5) @(negedge clk);
      check("R1 no request", hs_count, 0);
   endtask

   task automatic t_simple();
      start_frame(32'h1000, 16'd64, 16'd256, 12'd2);
      wait_done();
      check("R5 count", hs_count, 3);
      for (int i = 0; i < 3; i++) begin
         check("R3 addr", rec_addr[i], 32'h1000 + i * 256);
         check("R3 len", {28'd0, rec_len[i]}, 7);
      end
      check("R8 done", {31'd0, done}, 1);
      repeat (10) @(negedge clk);
      check("R8 idle after done", hs_count, 3);
   endtask

   task automatic t_split();
      start_frame(32'h2000, 16'd200, 16'd512, 12'd1);
      wait_done();
      check("R4 count", hs_count, 4);
      check("R4 a0", rec_addr[0], 32'h2000);
      check("R4 l0", {28'd0, rec_len[0]}, 15);
      check("R4 a1", rec_addr[1], 32'h2080);
      check("R4 l1", {28'd0, rec_len[1]}, 8);
      check("R4 a2", rec_addr[2], 32'h2200);
      check("R4 a3", rec_addr[3], 32'h2280);
      start_frame(32'h3004, 16'd20, 16'd64, 12'd0);
      wait_done();
      check("R3 round count", hs_count, 1);
      check("R3 round addr", rec_addr[0], 32'h3004);
      check("R3 round len", {28'd0, rec_len[0]}, 2);
   endtask

   task automatic t_stall_cfg();
      ready_en = 0;
      start_frame(32'h1000, 16'd64, 16'd256, 12'd2);
      repeat (2) @(negedge clk);
      check("R6 valid held", {31'd0, req_valid}, 1);
      check("R6 addr held", req_addr, 32'h1000);
      cfg_pitch = 16'h40; cfg_base = 32'h9000; cfg_lines_m1 = 12'd7;
      repeat (3) @(negedge clk);
      check("R6 addr still", req_addr, 32'h1000);
      ready_en = 1;
      wait_done();
      check("R2 count", hs_count, 3);
      check("R2 line2", rec_addr[2], 32'h1200);
   endtask

   task automatic t_credit();
      auto_cpl = 0;
      start_frame(32'h0, 16'd2048, 16'd2048, 12'd0);
      repeat (20) @(negedge clk);
      check("R7 limit", hs_count, 4);
      cpl_once = 1;
      repeat (10) @(negedge clk);
      check("R7 one more", hs_count, 5);
      auto_cpl = 1;
      wait_done();
      check("R7 total", hs_count, 16);
      check("R4 last addr", rec_addr[15], 32'h780);
   endtask

   task automatic t_restart();
      start_frame(32'h4000, 16'd2048, 16'd2048, 12'd3);
      repeat (3) @(negedge clk);
      ready_en = 0;
      start_frame(32'h8000, 16'd64, 16'd0, 12'd0);
      ready_en = 1;
      wait_done();
      check("R9 count", hs_count, 1);
      check("R9 addr", rec_addr[0], 32'h8000);
      check("R9 done", {31'd0, done}, 1);
   endtask

   task automatic t_zero();
      start_frame(32'h5000, 16'd0, 16'd64, 12'd3);
      check("R8 cleared by start", {31'd0, done}, 0);
      wait_done();
      check("R10 no requests", hs_count, 0);
      check("R10 done", {31'd0, done}, 1);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            @(negedge clk) rst_n = 1'b1;
            t_reset();
            t_simple();
            t_split();
            t_stall_cfg();
            t_credit();
            t_restart();
            t_zero();
         end
         begin
            repeat (100000) @(posedge clk);
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule